// File: doc/BRIEF.md
# Frame-Clocked DDR Serial ADC Deserializer

This block turns the serial output of a multi-channel sampling converter back into parallel sample words. Each channel arrives on its own data line. A bit clock and a frame clock are shared by all lanes. The bit clock runs at six times the sample rate, and data is taken on both of its edges, so twelve bits arrive per sample period. The frame clock runs at the sample rate, and its rising edge marks where a new word begins.

Inside, every lane keeps one capture flop per bit-clock edge and a short shift register. The control half watches the frame clock at each rising bit-clock edge and counts bit pairs between frame edges. On each frame boundary it tells the datapath to latch the finished word of every lane. All channels are presented together with one valid pulse and a flag that reports a wrong bit count. The outputs belong to the rising-edge bit-clock domain and change once per frame. Data reaches the block as logic levels that are already sampled, and the bit clock is supplied directly.

Top module: `ddr_frame_deser`

## Requirements
- R1: Words are WORD_BITS (12) bits and arrive most significant bit first. The bit sampled on the rising bit-clock edge where the frame clock is first seen high is bit 11. The next falling edge gives bit 10, and the bits then alternate between rising and falling edges down to bit 0.
- R2: Both bit-clock edges capture data, so a frame of six bit-clock periods delivers one complete 12-bit word per lane.
- R3: Each channel is deserialized from its own line, independently of the others. Channel c appears on `wordOut[c*12 +: 12]`.
- R4: On the rising bit-clock edge where a frame-clock rise is detected, `wordOut` is loaded with the previous frame's words and `wordValid` goes high. It stays high for exactly one bit-clock cycle.
- R5: After reset, the first frame-clock rise produces no valid pulse. The first pulse comes at the second rise, once one complete frame has been collected.
- R6: `wordMisaligned` is set together with `wordValid` when the number of bits between the two frame edges is not 12. The word is still emitted and holds the last 12 bits received. Otherwise the flag is 0.
- R7: `wordOut` keeps its value between valid pulses.
- R8: While reset is held, `wordValid` and `wordMisaligned` are 0 and `wordOut` is all zeros.
- R9: A frame clock that is already high when reset is released is not taken as a frame boundary. A boundary requires a low level followed by a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock at 6x the sample rate; data is taken on both edges |
| rstN | input | 1 | Active-low reset, synchronous to the rising edge of bitClk |
| frameClk | input | 1 | Frame clock at the sample rate; its rise starts a word |
| serialIn | input | CHANNELS | One serial data line per channel |
| wordOut | output | CHANNELS*WORD_BITS | Parallel words, with channel c at bits c*WORD_BITS and up |
| wordValid | output | 1 | One-cycle strobe marking newly loaded words |
| wordMisaligned | output | 1 | Set with wordValid when the frame held a bit count other than WORD_BITS |

## Verification
Some rules are checked by the assertions on every cycle:
- the valid strobe lasts a single cycle and only follows a detected frame edge;
- the misalignment flag never appears without the strobe;
- the first boundary after reset stays silent;
- the words do not move between strobes.

Other behaviour can only be shown by the bench's scenarios, because it needs known stimulus:
- the bit order across rising and falling edges;
- the mapping of channels onto the output bus;
- the value of a word taken from a long frame;
- the handling of a frame clock that is high as reset ends.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  // Strobes passed from the frame control to the lane datapath.
  typedef struct packed {
    logic frameStart;  // frame-clock rise seen at this rising bit-clock edge
    logic emit;        // latch completed words (a prior boundary exists)
  } ctrlStrobe_t;

endpackage

// File: rtl/ddr_deser_ctrl.sv
module ddr_deser_ctrl
  import ddr_deser_pkg::*;
#(
  parameter int PAIRS = 6
) (
  input  logic        bitClk,
  input  logic        rstN,
  input  logic        frameClk,
  output ctrlStrobe_t strobes,
  output logic        wordValid,
  output logic        wordMisaligned
);

  localparam int CW = $clog2(PAIRS + 1) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] LAST_PAIR = CW'(PAIRS - 1);

  logic          frameQ;
  logic          seenFrame;
  logic [CW-1:0] pairCnt;

  always_comb begin
    strobes.frameStart = frameClk & ~frameQ;
    strobes.emit       = strobes.frameStart & seenFrame;
  end

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      frameQ         <= 1'b1;  // a high level at release is not an edge (R9)
      seenFrame      <= 1'b0;
      pairCnt        <= '0;
      wordValid      <= 1'b0;
      wordMisaligned <= 1'b0;
    end else begin
      frameQ         <= frameClk;
      wordValid      <= strobes.emit;
      wordMisaligned <= strobes.emit && (pairCnt != LAST_PAIR);
      if (strobes.frameStart) begin
        seenFrame <= 1'b1;
        pairCnt   <= '0;
      end else if (pairCnt != CNT_MAX) begin
        pairCnt <= pairCnt + 1'b1;
      end
    end
  end

  // R4: the strobe lasts one cycle
  p_valid_single_r4: assert property (@(posedge bitClk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R4: the strobe only follows a detected frame edge
  p_valid_after_edge_r4: assert property (@(posedge bitClk) disable iff (!rstN)
    wordValid |-> $past(strobes.frameStart));

  // R6: the flag never stands alone
  p_flag_with_valid_r6: assert property (@(posedge bitClk) disable iff (!rstN)
    wordMisaligned |-> wordValid);

  // R5: the first boundary is silent
  p_first_edge_silent_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobes.frameStart && !seenFrame) |=> !wordValid);

endmodule

// File: rtl/ddr_deser_datapath.sv
module ddr_deser_datapath
  import ddr_deser_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int WORD_BITS = 12
) (
  input  logic                          bitClk,
  input  logic                          rstN,
  input  logic [CHANNELS-1:0]           serialIn,
  input  ctrlStrobe_t                   strobes,
  output logic [CHANNELS*WORD_BITS-1:0] wordOut
);

  localparam int SHIFT_BITS = WORD_BITS - 2;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    logic                  riseBit;
    logic                  fallBit;
    logic [SHIFT_BITS-1:0] shiftReg;
    logic [WORD_BITS-1:0]  wordReg;

    always_ff @(negedge bitClk) begin
      fallBit <= serialIn[ch];
    end

    always_ff @(posedge bitClk) begin
      riseBit  <= serialIn[ch];
      shiftReg <= {shiftReg[SHIFT_BITS-3:0], riseBit, fallBit};
    end

    always_ff @(posedge bitClk) begin
      if (!rstN) begin
        wordReg <= '0;
      end else if (strobes.emit) begin
        wordReg <= {shiftReg, riseBit, fallBit};
      end
    end

    assign wordOut[ch*WORD_BITS +: WORD_BITS] = wordReg;
  end

  // R7: words hold between emits
  p_hold_between_r7: assert property (@(posedge bitClk) disable iff (!rstN)
    !strobes.emit |=> $stable(wordOut));

  // R5: a boundary without a prior frame leaves the words untouched
  p_first_edge_hold_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobes.frameStart && !strobes.emit) |=> $stable(wordOut));

endmodule

// File: rtl/ddr_frame_deser.sv
module ddr_frame_deser
  import ddr_deser_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int WORD_BITS = 12
) (
  input  logic                          bitClk,
  input  logic                          rstN,
  input  logic                          frameClk,
  input  logic [CHANNELS-1:0]           serialIn,
  output logic [CHANNELS*WORD_BITS-1:0] wordOut,
  output logic                          wordValid,
  output logic                          wordMisaligned
);

  localparam int PAIRS = WORD_BITS / 2;

  ctrlStrobe_t strobes;

  ddr_deser_ctrl #(.PAIRS(PAIRS)) u_ctrl (
    .bitClk         (bitClk),
    .rstN           (rstN),
    .frameClk       (frameClk),
    .strobes        (strobes),
    .wordValid      (wordValid),
    .wordMisaligned (wordMisaligned)
  );

  ddr_deser_datapath #(.CHANNELS(CHANNELS), .WORD_BITS(WORD_BITS)) u_data (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .strobes  (strobes),
    .wordOut  (wordOut)
  );

  // R8: quiet outputs during reset
  p_reset_quiet_r8: assert property (@(posedge bitClk)
    $past(!rstN) && !rstN |-> (!wordValid && !wordMisaligned && wordOut == '0));

endmodule

// File: tb/sim_ddr_frame_deser.sv
module sim_ddr_frame_deser;

  localparam int CLK_PERIOD = 10;
  localparam int CH = 8;
  localparam int WB = 12;
  localparam int VW = CH * WB;

  logic          bitClk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameClk = 1'b0;
  logic [CH-1:0] serialIn = '0;
  logic [VW-1:0] wordOut;
  logic          wordValid;
  logic          wordMisaligned;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          obsValid, obsValid2, obsMis;
  logic [VW-1:0] obsData, obsLate;

  ddr_frame_deser #(.CHANNELS(CH), .WORD_BITS(WB)) u0 (
    .bitClk(bitClk), .rstN(rstN), .frameClk(frameClk), .serialIn(serialIn),
    .wordOut(wordOut), .wordValid(wordValid), .wordMisaligned(wordMisaligned)
  );

  always #(CLK_PERIOD / 2) bitClk = ~bitClk;

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mkWords(input int seed);
    logic [VW-1:0] v;
    for (int ch = 0; ch < CH; ch++)
      v[ch*WB +: WB] = WB'((seed * 13 + ch * 397) ^ 'hA5A);
    return v;
  endfunction

  // Sends one frame of len bit-clock periods; the last 12 bits carry words.
  task automatic sendFrame(input logic [VW-1:0] words, input int len);
    for (int p = 0; p < len; p++) begin
      int ri = 2 * (len - 1 - p) + 1;
      @(negedge bitClk); #1;
      frameClk = (p < len / 2);
      for (int ch = 0; ch < CH; ch++)
        serialIn[ch] = (ri < WB) ? words[ch*WB + ri] : 1'b0;
      @(posedge bitClk); #1;
      if (p == 0) begin
        obsValid = wordValid; obsMis = wordMisaligned; obsData = wordOut;
      end
      if (p == 1) obsValid2 = wordValid;
      if (p == len - 1) obsLate = wordOut;
      for (int ch = 0; ch < CH; ch++)
        serialIn[ch] = (ri - 1 < WB) ? words[ch*WB + ri - 1] : 1'b0;
    end
  endtask

  task automatic doReset(input logic frameLevel);
    @(negedge bitClk); #1;
    rstN = 1'b0; frameClk = frameLevel; serialIn = '0;
    repeat (3) @(posedge bitClk);
    @(negedge bitClk); #1;
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset(1'b0);
    chk("R8 valid", VW'(wordValid), '0);
    chk("R8 misaligned", VW'(wordMisaligned), '0);
    chk("R8 words", wordOut, '0);
  endtask

  task automatic testFirstFrame();
    logic [VW-1:0] a = mkWords(1);
    sendFrame(a, 6);
    chk("R5 no valid at first edge", VW'(obsValid), '0);
    sendFrame(mkWords(2), 6);
    chk("R5 valid at second edge", VW'(obsValid), VW'(1));
    chk("R1 R2 R3 words", obsData, a);
    chk("R6 aligned flag", VW'(obsMis), '0);
    chk("R4 single cycle", VW'(obsValid2), '0);
    chk("R7 held mid-frame", obsLate, a);
  endtask

  task automatic testPatterns();
    logic [VW-1:0] ones = '1;
    logic [VW-1:0] walk;
    for (int ch = 0; ch < CH; ch++) walk[ch*WB +: WB] = WB'(1) << ch;
    sendFrame(ones, 6);
    chk("R1 R3 previous frame", obsData, mkWords(2));
    sendFrame('0, 6);
    chk("R2 all ones", obsData, ones);
    sendFrame(walk, 6);
    chk("R2 all zeros", obsData, '0);
    sendFrame(mkWords(3), 6);
    chk("R1 R3 walking bit", obsData, walk);
    chk("R4 valid again", VW'(obsValid), VW'(1));
  endtask

  task automatic testMisaligned();
    logic [VW-1:0] f = mkWords(4);
    logic [VW-1:0] h = mkWords(6);
    sendFrame(f, 7);
    sendFrame(mkWords(5), 4);
    chk("R6 long frame flag", VW'({obsValid, obsMis}), VW'(2'b11));
    chk("R6 long frame keeps last bits", obsData, f);
    sendFrame(h, 6);
    chk("R6 short frame flag", VW'({obsValid, obsMis}), VW'(2'b11));
    sendFrame(mkWords(7), 6);
    chk("R6 realigned", VW'({obsValid, obsMis}), VW'(2'b10));
    chk("R6 realigned words", obsData, h);
  endtask

  task automatic testResetHigh();
    logic [VW-1:0] j = mkWords(8);
    logic sawValid = 1'b0;
    doReset(1'b1);
    repeat (4) begin
      @(posedge bitClk); #1;
      sawValid |= wordValid;
    end
    @(negedge bitClk); #1; frameClk = 1'b0;
    repeat (3) begin
      @(posedge bitClk); #1;
      sawValid |= wordValid;
    end
    chk("R9 high at release ignored", VW'(sawValid), '0);
    sendFrame(j, 6);
    chk("R9 first real edge silent", VW'(obsValid), '0);
    sendFrame(mkWords(9), 6);
    chk("R9 valid after real frame", VW'(obsValid), VW'(1));
    chk("R9 words after real frame", obsData, j);
  endtask

  initial begin
    testReset();
    testFirstFrame();
    testPatterns();
    testMisaligned();
    testResetHigh();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule